// File: doc/BRIEF.md
# Multi-Counter Event Monitor

This block is a bus-attached monitor with eight 32-bit event counters. A coherency controller supplies a 256-bit vector of one-cycle event pulses. Each counter has an 8-bit selector that picks one bit of that vector, and the counter advances by one in every cycle where that bit is high. A selector value of zero parks the counter. One global enable starts and stops all counters together.

Software sets the sample period of a counter by loading the two's-complement negative of that period. When the counter wraps from all-ones to zero it raises its overflow flag. If the counter's interrupt enable is also set, its own interrupt line goes high. The handler reloads the counter and then writes one to the flag to clear it.

The register bus is word-addressed. `addr_i` carries the byte offset divided by four, and byte strobes qualify each write lane. Reads are combinational from the address while a read request is present.

Top module: `evt_mon_unit`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low.
- R2: The selector of counter i sits at byte offset 0x04+i, which is word 1 lane i for i<4 and word 2 lane i-4. A strobed byte write changes only that selector, and the word reads back all four selectors of its group.
- R3: Counter i is read and written as a full 32-bit word at byte offset 0x0C+4i, which is word 3+i.
- R4: While control bit 0 (global enable) is clear, no counter advances.
- R5: A counter adds one in each cycle where its selected event bit is high, the global enable is set and its selector is nonzero. On a wrap from 0xFFFFFFFF to 0, control bit 16+i is set at that same clock edge, and counting continues from 0.
- R6: `irq_o[i]` is high exactly while overflow bit 16+i and interrupt enable bit 8+i are both set.
- R7: A selector of zero counts nothing, and a counter ignores every event bit other than the one it selects.
- R8: Writing 1 to control bit 16+i clears that overflow flag. Writing 0 leaves it unchanged.
- R9: Control bits 1 to 7 and 24 to 31 read as zero and ignore writes.
- R10: A software write to a counter takes priority over an increment in the same cycle.
- R11: If a wrap and a write-one-to-clear of the same flag fall in one cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 4 | Word address (byte offset / 4) |
| be_i | input | 4 | Byte strobes for the write lanes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero unless a read is requested |
| evt_i | input | 256 | Event pulses, indexed by selector value |
| irq_o | output | 8 | One interrupt line per counter |

## Verification
The bench builds the block with its default parameters: eight counters, 8-bit selectors and a 256-bit event vector. With these values the full control-word layout is in use, both selector words are filled, and the last counter sits at word 10, so the top of the address map is covered. Preloading counters near 0xFFFFFFFF brings the wrap edge within a few cycles. The same-cycle collisions are driven on purpose: a counter write against an increment, and a flag clear against a wrap.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned BE_W       = DATA_W / 8;
  localparam int unsigned IE_LSB     = 8;
  localparam int unsigned OVF_LSB    = 16;
  localparam int unsigned WORD_CTRL  = 0;
  localparam int unsigned WORD_SEL0  = 1;
  localparam int unsigned WORD_CNT0  = 3;

  function automatic int unsigned sel_word(int unsigned idx);
    return WORD_SEL0 + idx / BE_W;
  endfunction

  function automatic int unsigned sel_lane(int unsigned idx);
    return idx % BE_W;
  endfunction
endpackage

// File: rtl/evt_mon_counter.sv
module evt_mon_counter
  import evt_mon_pkg::*;
#(
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned NUM_EVT = 1 << SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic              sel_we_i,
  input  logic [SEL_W-1:0]  sel_wdata_i,
  input  logic [BE_W-1:0]   cnt_be_i,
  input  logic [DATA_W-1:0] cnt_wdata_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              wrap_o
);
  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              hit, wr_any;

  assign hit    = gen_i && (sel_q != '0) && evt_i[sel_q];
  assign wr_any = |cnt_be_i;
  assign wrap_o = hit && !wr_any && (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_any) begin
      for (int b = 0; b < int'(BE_W); b++)
        if (cnt_be_i[b]) cnt_d[8*b +: 8] = cnt_wdata_i[8*b +: 8];
    end else if (hit) begin
      cnt_d = cnt_q + DATA_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (sel_we_i) sel_q <= sel_wdata_i;
      cnt_q <= cnt_d;
    end
  end

  assign sel_o = sel_q;
  assign cnt_o = cnt_q;

  AST_SEL_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == '0 && !wr_any) |=> $stable(cnt_q)); // R7
  AST_GEN_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_i && !wr_any) |=> $stable(cnt_q)); // R4
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + DATA_W'(1))); // R5
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_be_i) |=> cnt_q == $past(cnt_wdata_i)); // R10
endmodule

// File: rtl/evt_mon_ctrl.sv
module evt_mon_ctrl
  import evt_mon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gen_we_i,
  input  logic               gen_d_i,
  input  logic               ie_we_i,
  input  logic [NUM_CNT-1:0] ie_d_i,
  input  logic [NUM_CNT-1:0] clr_i,
  input  logic [NUM_CNT-1:0] wrap_i,
  output logic               gen_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic [NUM_CNT-1:0] irq_o
);
  logic               gen_q;
  logic [NUM_CNT-1:0] ie_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= 1'b0;
      ie_q  <= '0;
      ovf_q <= '0;
    end else begin
      if (gen_we_i) gen_q <= gen_d_i;
      if (ie_we_i)  ie_q  <= ie_d_i;
      ovf_q <= (ovf_q & ~clr_i) | wrap_i; // set beats clear
    end
  end

  always_comb begin
    ctrl_o                     = '0;
    ctrl_o[0]                  = gen_q;
    ctrl_o[IE_LSB +: NUM_CNT]  = ie_q;
    ctrl_o[OVF_LSB +: NUM_CNT] = ovf_q;
  end

  assign gen_o = gen_q;
  assign irq_o = ovf_q & ie_q;

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i != '0) |=> ((ovf_q & $past(wrap_i)) == $past(wrap_i))); // R11
  AST_OVF_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ovf_q & ~$past(ovf_q)) & ~$past(wrap_i)) == '0); // R5
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(ovf_q) & ~ovf_q) & ~$past(clr_i)) == '0); // R8
endmodule

// File: rtl/evt_mon_regif.sv
module evt_mon_regif
  import evt_mon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned WORD_W  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [WORD_W-1:0]             addr_i,
  input  logic [BE_W-1:0]               be_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [DATA_W-1:0]             ctrl_q_i,
  input  logic [NUM_CNT-1:0][SEL_W-1:0] sel_q_i,
  input  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_q_i,
  output logic                          gen_we_o,
  output logic                          gen_d_o,
  output logic                          ie_we_o,
  output logic [NUM_CNT-1:0]            ie_d_o,
  output logic [NUM_CNT-1:0]            clr_o,
  output logic [NUM_CNT-1:0]            sel_we_o,
  output logic [NUM_CNT-1:0][SEL_W-1:0] sel_wdata_o,
  output logic [NUM_CNT-1:0][BE_W-1:0]  cnt_be_o,
  output logic [DATA_W-1:0]             rdata_o
);
  logic wr, rd, ctrl_hit;
  logic [DATA_W-1:0] rd_word;

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign ctrl_hit = addr_i == WORD_W'(WORD_CTRL);

  assign gen_we_o = wr && ctrl_hit && be_i[0];
  assign gen_d_o  = wdata_i[0];
  assign ie_we_o  = wr && ctrl_hit && be_i[IE_LSB/8];
  assign ie_d_o   = wdata_i[IE_LSB +: NUM_CNT];
  assign clr_o    = (wr && ctrl_hit && be_i[OVF_LSB/8]) ? wdata_i[OVF_LSB +: NUM_CNT] : '0;

  for (genvar i = 0; i < int'(NUM_CNT); i++) begin : g_dec
    localparam int unsigned SW = sel_word(i);
    localparam int unsigned SL = sel_lane(i);
    assign sel_we_o[i]    = wr && (addr_i == WORD_W'(SW)) && be_i[SL];
    assign sel_wdata_o[i] = wdata_i[8*SL +: SEL_W];
    assign cnt_be_o[i]    = (wr && (addr_i == WORD_W'(WORD_CNT0 + i))) ? be_i : '0;
  end

  always_comb begin
    rd_word = '0;
    if (ctrl_hit) rd_word = ctrl_q_i;
    for (int i = 0; i < int'(NUM_CNT); i++) begin
      if (addr_i == WORD_W'(sel_word(i)))
        rd_word[8*sel_lane(i) +: SEL_W] = sel_q_i[i];
      if (addr_i == WORD_W'(WORD_CNT0 + i))
        rd_word = cnt_q_i[i];
    end
  end

  assign rdata_o = rd ? rd_word : '0;

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && ctrl_hit) |-> (rdata_o[7:1] == '0 && rdata_o[31:24] == '0)); // R9
endmodule

// File: rtl/evt_mon_unit.sv
module evt_mon_unit
  import evt_mon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 8,
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned WORD_W  = 4,
  localparam int unsigned NUM_EVT = 1 << SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [WORD_W-1:0]  addr_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [NUM_CNT-1:0] irq_o
);
  logic                           gen_we, gen_d, ie_we, gen;
  logic [NUM_CNT-1:0]             ie_d, clr, sel_we, wrap;
  logic [DATA_W-1:0]              ctrl_q;
  logic [NUM_CNT-1:0][SEL_W-1:0]  sel_q, sel_wdata;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_q;
  logic [NUM_CNT-1:0][BE_W-1:0]   cnt_be;

  evt_mon_regif #(.NUM_CNT(NUM_CNT), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i,
    .ctrl_q_i(ctrl_q), .sel_q_i(sel_q), .cnt_q_i(cnt_q),
    .gen_we_o(gen_we), .gen_d_o(gen_d), .ie_we_o(ie_we), .ie_d_o(ie_d),
    .clr_o(clr), .sel_we_o(sel_we), .sel_wdata_o(sel_wdata),
    .cnt_be_o(cnt_be), .rdata_o
  );

  evt_mon_ctrl #(.NUM_CNT(NUM_CNT)) u_ctrl (
    .clk_i, .rst_ni, .gen_we_i(gen_we), .gen_d_i(gen_d),
    .ie_we_i(ie_we), .ie_d_i(ie_d), .clr_i(clr), .wrap_i(wrap),
    .gen_o(gen), .ctrl_o(ctrl_q), .irq_o
  );

  for (genvar i = 0; i < int'(NUM_CNT); i++) begin : g_cnt
    evt_mon_counter #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_cnt (
      .clk_i, .rst_ni, .gen_i(gen), .evt_i,
      .sel_we_i(sel_we[i]), .sel_wdata_i(sel_wdata[i]),
      .cnt_be_i(cnt_be[i]), .cnt_wdata_i(wdata_i),
      .sel_o(sel_q[i]), .cnt_o(cnt_q[i]), .wrap_o(wrap[i])
    );
  end
endmodule

// File: tb/evt_mon_unit_bench.sv
`timescale 1ns/1ps
module evt_mon_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [255:0] evt = '0;
  logic [7:0]  irq;

  int n_chk = 0, n_fail = 0;
  bit mon_vld = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  evt_mon_unit u_evt_mon_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  // monitor: pops one expected item per flagged cycle
  always @(negedge clk) begin
    if (mon_vld && exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.is_irq ? {24'h0, irq} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d);
    @(posedge clk); #1 req = 1; we = 1; addr = a; be = b; wdata = d;
    @(posedge clk); #1 req = 0; we = 0; be = '0;
  endtask

  task automatic wr_evt(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d,
                        input int idx);
    @(posedge clk); #1 req = 1; we = 1; addr = a; be = b; wdata = d; evt[idx] = 1'b1;
    @(posedge clk); #1 req = 0; we = 0; be = '0; evt = '0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    @(posedge clk); #1 req = 1; we = 0; addr = a; exp_q.push_back(it); mon_vld = 1;
    @(posedge clk); #1 req = 0; mon_vld = 0;
  endtask

  task automatic irq_chk(input logic [7:0] e, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {24'h0, e}; it.tag = tag;
    @(posedge clk); #1 exp_q.push_back(it); mon_vld = 1;
    @(posedge clk); #1 mon_vld = 0;
  endtask

  task automatic pulse(input int idx, input int n);
    repeat (n) begin @(posedge clk); #1 evt[idx] = 1'b1; end
    @(posedge clk); #1 evt = '0;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(4'd0,  32'h0, "R1 ctrl");
    rd_chk(4'd1,  32'h0, "R1 sel0-3");
    rd_chk(4'd3,  32'h0, "R1 cnt0");
    irq_chk(8'h00, "R1 irq");

    // R2 selector byte writes
    wr(4'd1, 4'b0001, 32'h0000_0005);
    wr(4'd1, 4'b0010, 32'h0000_0700);
    wr(4'd1, 4'b1000, 32'h0900_0000);
    rd_chk(4'd1, 32'h0900_0705, "R2 sel word1");
    wr(4'd2, 4'b1000, 32'hAA00_0000);
    rd_chk(4'd2, 32'hAA00_0000, "R2 sel7 lane");
    rd_chk(4'd1, 32'h0900_0705, "R2 neighbours kept");

    // R3 counter access
    wr(4'd10, 4'b1111, 32'h1234_5678);
    rd_chk(4'd10, 32'h1234_5678, "R3 cnt7");
    wr(4'd3, 4'b1111, 32'hFFFF_FFFD);
    rd_chk(4'd3, 32'hFFFF_FFFD, "R3 cnt0");

    // R4 global enable off
    pulse(5, 3);
    rd_chk(4'd3, 32'hFFFF_FFFD, "R4 no count");

    // R5 counting and wrap
    wr(4'd0, 4'b1111, 32'h0000_0101);
    pulse(5, 2);
    rd_chk(4'd3, 32'hFFFF_FFFF, "R5 count");
    rd_chk(4'd0, 32'h0000_0101, "R5 no ovf yet");
    irq_chk(8'h00, "R6 irq low");
    pulse(5, 1);
    rd_chk(4'd3, 32'h0, "R5 wrap");
    rd_chk(4'd0, 32'h0001_0101, "R5 ovf set");
    irq_chk(8'h01, "R6 irq high");
    pulse(5, 2);
    rd_chk(4'd3, 32'h2, "R5 keeps counting");

    // R7 zero selector and unselected events
    rd_chk(4'd4, 32'h0, "R7 cnt1 ignores evt5");
    pulse(0, 3);
    rd_chk(4'd5, 32'h0, "R7 sel zero");

    // R8 write-one-to-clear
    wr(4'd0, 4'b1111, 32'h0000_0101);
    rd_chk(4'd0, 32'h0001_0101, "R8 zero keeps");
    wr(4'd0, 4'b1111, 32'h0001_0101);
    rd_chk(4'd0, 32'h0000_0101, "R8 one clears");
    irq_chk(8'h00, "R8 irq cleared");

    // R9 reserved bits
    wr(4'd0, 4'b1111, 32'hFF00_01FF);
    rd_chk(4'd0, 32'h0000_0101, "R9 reserved");

    // R10 write beats increment
    wr_evt(4'd4, 4'b1111, 32'h0000_0100, 7);
    rd_chk(4'd4, 32'h0000_0100, "R10 write wins");
    pulse(7, 1);
    rd_chk(4'd4, 32'h0000_0101, "R5 cnt1 counts");

    // R6 interrupt disabled
    wr(4'd6, 4'b1111, 32'hFFFF_FFFF);
    pulse(9, 1);
    rd_chk(4'd0, 32'h0008_0101, "R6 ovf3 set");
    irq_chk(8'h00, "R6 ie3 off");

    // R11 set beats clear
    wr(4'd6, 4'b1111, 32'hFFFF_FFFF);
    wr_evt(4'd0, 4'b1111, 32'h0008_0101, 9);
    rd_chk(4'd0, 32'h0008_0101, "R11 set wins");
    rd_chk(4'd6, 32'h0, "R11 cnt3 wrapped");
    wr(4'd0, 4'b1111, 32'h0008_0901);
    rd_chk(4'd0, 32'h0000_0901, "R8 clear ovf3");
    wr(4'd6, 4'b1111, 32'hFFFF_FFFF);
    pulse(9, 1);
    irq_chk(8'h08, "R6 irq3 high");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule